// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

A purely combinational datapath block that serves shift and rotate micro-operations in an integer execution pipe. It receives the first source value, a count operand, an operand size of 1, 2, 4 or 8 bytes, the incoming carry flag and the current contents of the destination register. From these it computes the new destination value. The shift or rotate result is formed within the selected operand width and then written into the old destination value under the usual partial-register rule.

Seven operations are supported: shift left, logical shift right, arithmetic shift right, rotate right, rotate left, and rotate right or left through carry. A rotate whose masked count is zero does not write the destination, so the old value passes through unchanged. Flag outputs are produced elsewhere.

Operation codes on `op_sel` are: 0 shift left, 1 logical shift right, 2 arithmetic shift right, 3 rotate right, 4 rotate left, 5 rotate right through carry, 6 rotate left through carry, and 7 no write. Size codes on `size_sel` are 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. W below is the operand width in bits.

Top module: `shrot_unit`

## Requirements
- R1: The effective count n is `count_in & 0x3F` at size code 3 and `count_in & 0x1F` at every other size. Count bits above the mask have no effect.
- R2: Shift left (op 0) moves the operand toward the MSB and fills vacated low bits with zeros. If n is W or more, the width-limited result is zero.
- R3: Logical shift right (op 1) clears every vacated top bit inside W. Source bits above W never appear in the result.
- R4: Arithmetic shift right (op 2) fills vacated top bits with source bit W-1. If n is W or more, every bit inside W equals that sign bit.
- R5: Rotate right (op 3) and rotate left (op 4) rotate the W-bit operand by n mod W positions. A nonzero n that is a multiple of W writes the operand unchanged.
- R6: Rotate right through carry (op 5) rotates the (W+1)-bit value {CF, operand} right by n mod (W+1). The result is its low W bits, which puts CF at bit W-n and the operand's low n-1 bits directly above it.
- R7: Rotate left through carry (op 6) rotates {CF, operand} left by n mod (W+1). This puts CF at bit n-1 and the operand's top n-1 bits in bits n-2..0.
- R8: Any rotate (ops 3 to 6) with n equal to 0, and op code 7 at any count, returns `dest_old` unchanged in all 64 bits.
- R9: When written, 8- and 16-bit results keep `dest_old` bits above W, 32-bit results clear bits 63..32, and 64-bit results replace the whole value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 64 | Value being shifted or rotated |
| count_in | input | 8 | Count operand before masking |
| size_sel | input | 2 | Operand size code (0 to 3) |
| op_sel | input | 3 | Operation code (0 to 7) |
| carry_in | input | 1 | Incoming carry flag for the through-carry rotates |
| dest_old | input | 64 | Current destination contents |
| dest_new | output | 64 | Merged destination result |

## Verification
The bench builds the block with its default 64-bit datapath and 8-bit count operand. With these values all four operand sizes are reachable. So is the difference between the 5-bit and 6-bit count masks. It also reaches counts at and beyond the 8- and 16-bit widths, which exercise the wrap of plain rotates modulo W and of carry rotates modulo W+1.

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int DW    = 64,
  parameter int CNT_W = 8
) (
  input  logic [DW-1:0]    src_a,
  input  logic [CNT_W-1:0] count_in,
  input  logic [1:0]       size_sel,
  input  logic [2:0]       op_sel,
  input  logic             carry_in,
  input  logic [DW-1:0]    dest_old,
  output logic [DW-1:0]    dest_new
);
  localparam int CW = $clog2(DW);

  localparam logic [2:0] OP_SHL = 3'd0, OP_SHR = 3'd1, OP_SAR = 3'd2,
                         OP_ROR = 3'd3, OP_ROL = 3'd4, OP_RCR = 3'd5,
                         OP_RCL = 3'd6;

  function automatic logic [DW:0] rot_right(input logic [DW:0] v,
                                            input logic [CW:0] w,
                                            input logic [CW:0] r);
    logic [DW:0] o;
    logic [CW:0] idx;
    o = '0;
    for (int i = 0; i <= DW; i++) begin
      if (i < int'(w)) begin
        idx = (CW+1)'((i + int'(r)) % int'(w));
        o[i] = v[idx];
      end
    end
    return o;
  endfunction

  logic [CW:0]   w, wc, r_w, r_c;
  logic [CW-1:0] n, msb;
  logic [DW-1:0] wmask, s, res;
  logic [DW:0]   vc, rot_o;
  logic          sign, is_rot, no_write;

  assign w     = (CW+1)'(8) << size_sel;
  assign wc    = w + 1'b1;
  assign msb   = CW'(w - 1'b1);
  assign n     = (size_sel == 2'd3) ? count_in[CW-1:0] : {1'b0, count_in[CW-2:0]};
  assign wmask = (size_sel == 2'd3) ? '1 : ((DW'(1) << w) - DW'(1));
  assign s     = src_a & wmask;
  assign sign  = src_a[msb];
  assign r_w   = (CW+1)'({1'b0, n} % w);
  assign r_c   = (CW+1)'({1'b0, n} % wc);
  assign vc    = {1'b0, s} | ((DW+1)'(carry_in) << w);

  assign is_rot   = (op_sel >= OP_ROR) && (op_sel <= OP_RCL);
  assign no_write = (op_sel == 3'd7) || (is_rot && (n == '0));

  always_comb begin
    rot_o = '0;
    case (op_sel)
      OP_ROR:  rot_o = rot_right({1'b0, s}, w, r_w);
      OP_ROL:  rot_o = rot_right({1'b0, s}, w, (CW+1)'((w - r_w) % w));
      OP_RCR:  rot_o = rot_right(vc, wc, r_c);
      OP_RCL:  rot_o = rot_right(vc, wc, (CW+1)'((wc - r_c) % wc));
      default: rot_o = '0;
    endcase
  end

  always_comb begin
    case (op_sel)
      OP_SHL:  res = (s << n) & wmask;
      OP_SHR:  res = s >> n;
      OP_SAR:  res = (s >> n) | (sign ? (wmask & ~(wmask >> n)) : '0);
      default: res = rot_o[DW-1:0] & wmask;
    endcase
  end

  always_comb begin
    if (no_write)
      dest_new = dest_old;
    else
      case (size_sel)
        2'd0:    dest_new = {dest_old[DW-1:8],  res[7:0]};
        2'd1:    dest_new = {dest_old[DW-1:16], res[15:0]};
        2'd2:    dest_new = {{(DW-32){1'b0}},   res[31:0]};
        default: dest_new = res;
      endcase
  end

  always_comb begin
    if (!$isunknown({src_a, count_in, size_sel, op_sel, carry_in, dest_old})) begin
      a_r8_rot_zero_hold: assert (!(is_rot && n == '0) || dest_new == dest_old)
        else $error("zero-count rotate changed destination");
      a_r9_keep_upper: assert (!(size_sel < 2'd2) || ((dest_new & ~wmask) == (dest_old & ~wmask)))
        else $error("narrow write disturbed upper bits");
      a_r9_clear_upper: assert (!(size_sel == 2'd2 && !no_write) || dest_new[DW-1:32] == '0)
        else $error("32-bit write left upper bits set");
      a_r5_rot_popcount: assert (!((op_sel == OP_ROR || op_sel == OP_ROL) && n != '0) ||
                                 $countones(dest_new & wmask) == $countones(s))
        else $error("rotate lost or gained bits");
      a_r3_top_clear: assert (!(op_sel == OP_SHR && n != '0 && {1'b0, n} < w) || dest_new[msb] == 1'b0)
        else $error("logical shift right left top bit set");
      a_r4_top_sign: assert (!(op_sel == OP_SAR && n != '0) || dest_new[msb] == sign)
        else $error("arithmetic shift right lost sign");
    end
  end
endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
  logic        clk = 1'b0;
  logic [63:0] src_a = '0, dest_old = '0;
  logic [7:0]  count_in = '0;
  logic [1:0]  size_sel = 2'd3;
  logic [2:0]  op_sel = 3'd0;
  logic        carry_in = 1'b0;
  logic [63:0] dest_new;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shrot_unit dut (.src_a(src_a), .count_in(count_in), .size_sel(size_sel),
                  .op_sel(op_sel), .carry_in(carry_in), .dest_old(dest_old),
                  .dest_new(dest_new));

  task automatic run(input logic [2:0] op, input logic [1:0] sz, input logic [63:0] src,
                     input logic [7:0] cnt, input logic cf, input logic [63:0] old,
                     input string req, input logic [63:0] exp);
    @(negedge clk);
    op_sel = op; size_sel = sz; src_a = src; count_in = cnt; carry_in = cf; dest_old = old;
    #3;
    tests++;
    if (dest_new !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, dest_new, exp);
    end
  endtask

  task automatic t_idle;
    run(3'd0, 2'd3, 64'h0, 8'd0, 1'b0, 64'h0, "R2 idle", 64'h0);
  endtask

  task automatic t_shl;
    run(3'd0, 2'd3, 64'hF1, 8'd4, 1'b0, 64'h0, "R2 shl 64", 64'hF10);
    run(3'd0, 2'd0, 64'h81, 8'd1, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, "R2 shl 8", 64'hAAAA_AAAA_AAAA_AA02);
    run(3'd0, 2'd0, 64'h81, 8'd9, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, "R2 shl past width", 64'hAAAA_AAAA_AAAA_AA00);
  endtask

  task automatic t_mask;
    run(3'd0, 2'd3, 64'h1, 8'h41, 1'b0, 64'h0, "R1 mask 6 bits", 64'h2);
    run(3'd0, 2'd2, 64'h1, 8'h21, 1'b0, '1, "R1 mask 5 bits", 64'h2);
    run(3'd0, 2'd2, 64'h1, 8'h20, 1'b0, '1, "R1 count masked to zero", 64'h1);
  endtask

  task automatic t_shr;
    run(3'd1, 2'd1, 64'hFFFF_FFFF_FFFF_8000, 8'd4, 1'b0, 64'h1111_2222_3333_4444, "R3 shr 16", 64'h1111_2222_3333_0800);
    run(3'd1, 2'd3, 64'h8000_0000_0000_0000, 8'd63, 1'b0, 64'h0, "R3 shr 63", 64'h1);
  endtask

  task automatic t_sar;
    run(3'd2, 2'd1, 64'hFFFF_FFFF_FFFF_8000, 8'd4, 1'b0, 64'h1111_2222_3333_4444, "R4 sar neg", 64'h1111_2222_3333_F800);
    run(3'd2, 2'd0, 64'h40, 8'd3, 1'b0, 64'h0, "R4 sar pos", 64'h08);
    run(3'd2, 2'd3, 64'h8000_0000_0000_0000, 8'd63, 1'b0, 64'h0, "R4 sar 63", '1);
    run(3'd2, 2'd0, 64'h80, 8'd20, 1'b0, 64'h0, "R4 sar past width", 64'hFF);
  endtask

  task automatic t_rot;
    run(3'd3, 2'd0, 64'h01, 8'd1, 1'b0, 64'h0, "R5 ror 8", 64'h80);
    run(3'd4, 2'd0, 64'h81, 8'd1, 1'b0, 64'h0, "R5 rol 8", 64'h03);
    run(3'd3, 2'd3, 64'h1, 8'd4, 1'b0, 64'h0, "R5 ror 64", 64'h1000_0000_0000_0000);
    run(3'd3, 2'd0, 64'h01, 8'd9, 1'b0, 64'h0, "R5 ror wrap", 64'h80);
    run(3'd4, 2'd0, 64'h81, 8'd8, 1'b0, 64'h0000_0000_0000_FF00, "R5 rol full turn", 64'hFF81);
  endtask

  task automatic t_rcr;
    run(3'd5, 2'd0, 64'h01, 8'd1, 1'b1, 64'h0, "R6 rcr cf in", 64'h80);
    run(3'd5, 2'd0, 64'h03, 8'd2, 1'b0, 64'h0, "R6 rcr 2", 64'h80);
    run(3'd5, 2'd1, 64'h1234, 8'd17, 1'b1, 64'h0, "R6 rcr wrap", 64'h1234);
  endtask

  task automatic t_rcl;
    run(3'd6, 2'd0, 64'h80, 8'd1, 1'b1, 64'h0, "R7 rcl 1", 64'h01);
    run(3'd6, 2'd0, 64'hA0, 8'd3, 1'b1, 64'h0, "R7 rcl 3", 64'h06);
    run(3'd6, 2'd3, 64'h8000_0000_0000_0000, 8'd1, 1'b0, 64'h0, "R7 rcl 64", 64'h0);
  endtask

  task automatic t_hold;
    run(3'd3, 2'd3, 64'h1234, 8'h40, 1'b0, 64'hDEAD_BEEF_0BAD_F00D, "R8 ror count zero", 64'hDEAD_BEEF_0BAD_F00D);
    run(3'd6, 2'd2, 64'h1234, 8'd0, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, "R8 rcl count zero", 64'hDEAD_BEEF_0BAD_F00D);
    run(3'd7, 2'd3, 64'h1234, 8'd5, 1'b1, 64'hCAFE_0000_1111_2222, "R8 op 7", 64'hCAFE_0000_1111_2222);
  endtask

  task automatic t_merge;
    run(3'd0, 2'd2, 64'hFFFF_FFFF_1234_5678, 8'd0, 1'b0, '1, "R9 32-bit clears upper", 64'h1234_5678);
    run(3'd1, 2'd3, 64'h0123_4567_89AB_CDEF, 8'd0, 1'b0, '1, "R9 64-bit replace", 64'h0123_4567_89AB_CDEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle; t_shl; t_mask; t_shr; t_sar; t_rot; t_rcr; t_rcl; t_hold; t_merge;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule